// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead Time

This block is one output channel of a motor-drive PWM unit. It does not own a counter of its own for the carrier. Instead it watches an external triangular time base that counts 1, 2, ..., peak, peak-1, ..., 2 and then returns to 1. Each pass of the time base through the value 1 marks the start of a switching period. A compare value A1 is matched twice per period, once on the rising slope and once on the falling slope, and these two matches give a pulse centred on the peak. A dead-time length B1, in clock cycles, is counted by a small counter inside the channel. The dead time delays either the leading edge or the trailing edge of the pulse, as a mode input selects.

Software writes A1 and B1 only through shadow registers. Both values move into the working registers together at the start of a period, so a pulse never mixes old and new settings. A polarity input decides whether the pulse is driven high over an idle-low output or low over an idle-high output. A half-bridge leg uses two such channels with the same compare value. The high-side switch uses leading-edge delay with the high-pulse polarity. The low-side switch uses trailing-edge delay with the low-pulse polarity. This leaves B1 clock cycles in which both switches are off on each side of the pulse.

Top module: `pwm_dt_channel`

## Requirements
- R1: After reset, and while `en_i` is 0, the output rests at its idle level, which equals `neg_pol_i`.
- R2: A clock on which `en_i` is 0 makes the output idle from the next clock on. After `en_i` goes to 1, the output stays idle until a clock on which `tbase_i` equals 1 (the period start), and the channel acts from that clock on.
- R3: A write to the A or B shadow (through `sh_a_we_i` or `sh_b_we_i`) reaches the working value on the next clock with `tbase_i` equal to 1. Compares made on that same clock already use the new value, and a period that is under way keeps its old values.
- R4: Leading mode (`lead_mode_i` = 1): the first clock t of a period on which `tbase_i` equals A1 starts the dead-time counter, and the output is active from clock t+B1 on.
- R5: Leading mode: the second A1 match of the period makes the output idle on the next clock. Dead-time expiry has no effect unless a first A1 match has armed it in the current period or run.
- R6: Trailing mode (`lead_mode_i` = 0): the first A1 match of a period makes the output active on the next clock.
- R7: Trailing mode: the second A1 match at clock t starts the dead-time counter, and the output returns to idle from clock t+B1 on.
- R8: With peak P and 1 < A1 < P, the active pulse lasts 2(P−A1)−B1 clocks in leading mode and 2(P−A1)+B1 clocks in trailing mode.
- R9: The output equals the internal active state XOR `neg_pol_i`. It is high when active for `neg_pol_i` = 0 and low when active for `neg_pol_i` = 1, and it follows a change of `neg_pol_i` with no clock delay.
- R10: A dead time of B1 = 0 behaves exactly like B1 = 1.
- R11: An A1 value that the time base never reaches (A1 greater than the peak) produces no match, so the output stays idle for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Channel enable; 0 forces idle |
| lead_mode_i | input | 1 | 1 = dead time on the leading edge, 0 = on the trailing edge |
| neg_pol_i | input | 1 | Output polarity; 0 = high pulse, 1 = low pulse |
| tbase_i | input | W | External triangular time base; value 1 marks the period start |
| sh_a_we_i | input | 1 | Write strobe for the compare shadow |
| sh_a_i | input | W | Compare value written into the shadow |
| sh_b_we_i | input | 1 | Write strobe for the dead-time shadow |
| sh_b_i | input | W | Dead-time value (clock cycles) written into the shadow |
| pwm_o | output | 1 | PWM output |

## Verification
The bench measures, for each period, the index of the first active clock, the index of the last active clock and the pulse width. A design that started the dead-time counter one clock late, or that cleared the pulse on the falling-slope match without waiting, moves these indices and changes the width by one or by B1. A shadow write made halfway through a period must leave the rest of that period unchanged. When the compare value is 1, the match on the period-start clock itself must use the new value, which catches a reload that lags by one clock. The bench also switches the enable off in the middle of a pulse and back on in the middle of a period, feeds a compare value above the peak, and compares a dead time of zero against a dead time of one. A design that let a stale pulse survive, started acting before the period boundary, or counted zero differently would show an active output where none is expected.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // How many compare matches have been seen in the current period
  typedef enum logic [1:0] {
    MATCH_NONE = 2'd0,
    MATCH_ONE  = 2'd1,
    MATCH_TWO  = 2'd2
  } match_cnt_e;

endpackage

// File: rtl/pwm_dt_rst_sync.sv
module pwm_dt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_dt_shadow.sv
module pwm_dt_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pstart_i,
  input  logic         a_we_i,
  input  logic [W-1:0] a_din_i,
  input  logic         b_we_i,
  input  logic [W-1:0] b_din_i,
  output logic [W-1:0] a_eff_o,
  output logic [W-1:0] b_eff_o
);

  logic [W-1:0] a_sh_q, a_sh_d;
  logic [W-1:0] b_sh_q, b_sh_d;
  logic [W-1:0] a_wk_q, a_wk_d;
  logic [W-1:0] b_wk_q, b_wk_d;

  always_comb begin
    a_sh_d = a_sh_q;
    b_sh_d = b_sh_q;
    a_wk_d = a_wk_q;
    b_wk_d = b_wk_q;
    if (a_we_i) a_sh_d = a_din_i;
    if (b_we_i) b_sh_d = b_din_i;
    if (pstart_i) begin
      a_wk_d = a_sh_q;
      b_wk_d = b_sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh_q <= '0;
      b_sh_q <= '0;
      a_wk_q <= '0;
      b_wk_q <= '0;
    end else begin
      a_sh_q <= a_sh_d;
      b_sh_q <= b_sh_d;
      a_wk_q <= a_wk_d;
      b_wk_q <= b_wk_d;
    end
  end

  // On the period-start clock the freshly loaded values are already in force
  assign a_eff_o = pstart_i ? a_sh_q : a_wk_q;
  assign b_eff_o = pstart_i ? b_sh_q : b_wk_q;

  AST_RELOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    pstart_i |=> (a_wk_q == $past(a_sh_q)) && (b_wk_q == $past(b_sh_q))); // R3
  AST_WORK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pstart_i |=> $stable(a_wk_q) && $stable(b_wk_q)); // R3

endmodule

// File: rtl/pwm_dt_delay_cnt.sv
module pwm_dt_delay_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | (run_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? CNT_ONE : cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) && !clr_i |=> cnt_q == CNT_MAX); // R4
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == CNT_ONE); // R7

endmodule

// File: rtl/pwm_dt_edge_ctrl.sv
module pwm_dt_edge_ctrl
  import pwm_dt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         lead_i,
  input  logic         pstart_i,
  input  logic [W-1:0] tbase_i,
  input  logic [W-1:0] a_eff_i,
  input  logic [W-1:0] b_eff_i,
  input  logic [W-1:0] cnt_i,
  output logic         cnt_clr_o,
  output logic         armed_o,
  output logic         active_o
);

  logic       run_q, run_d;
  logic       armed_q, armed_d;
  logic       act_q, act_d;
  match_cnt_e mc_q, mc_d, mc_cur;
  logic       run_eff, a_hit, b_hit, a_take;

  always_comb begin
    run_eff   = en_i & (run_q | pstart_i);
    mc_cur    = pstart_i ? MATCH_NONE : mc_q;
    a_hit     = run_eff & (tbase_i == a_eff_i);
    b_hit     = run_eff & armed_q & (cnt_i >= b_eff_i);
    a_take    = a_hit & (mc_cur != MATCH_TWO);
    run_d     = run_eff;
    mc_d      = mc_cur;
    armed_d   = armed_q;
    act_d     = act_q;
    cnt_clr_o = 1'b0;
    if (!en_i) begin
      run_d   = 1'b0;
      mc_d    = MATCH_NONE;
      armed_d = 1'b0;
      act_d   = 1'b0;
    end else if (a_take) begin
      cnt_clr_o = 1'b1;
      if (mc_cur == MATCH_NONE) begin
        mc_d = MATCH_ONE;
        if (lead_i) begin
          armed_d = 1'b1;
        end else begin
          act_d   = 1'b1;
          armed_d = 1'b0;
        end
      end else begin
        mc_d = MATCH_TWO;
        if (lead_i) begin
          act_d   = 1'b0;
          armed_d = 1'b0;
        end else begin
          armed_d = 1'b1;
        end
      end
    end else if (b_hit) begin
      armed_d = 1'b0;
      act_d   = lead_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mc_q    <= MATCH_NONE;
      armed_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      mc_q    <= mc_d;
      armed_q <= armed_d;
      act_q   <= act_d;
    end
  end

  assign armed_o  = armed_q;
  assign active_o = act_q;

  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !act_q); // R2
  AST_WAIT_FOR_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !pstart_i |=> !act_q); // R2
  AST_LEAD_SECOND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && lead_i && a_hit && (mc_cur == MATCH_ONE) |=> !act_q); // R5
  AST_TRAIL_FIRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !lead_i && a_hit && (mc_cur == MATCH_NONE) |=> act_q); // R6
  AST_ARMED_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> run_q); // R5

endmodule

// File: rtl/pwm_dt_channel.sv
module pwm_dt_channel #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         en_i,
  input  logic         lead_mode_i,
  input  logic         neg_pol_i,
  input  logic [W-1:0] tbase_i,
  input  logic         sh_a_we_i,
  input  logic [W-1:0] sh_a_i,
  input  logic         sh_b_we_i,
  input  logic [W-1:0] sh_b_i,
  output logic         pwm_o
);

  localparam logic [W-1:0] TB_START = W'(1);

  logic         rst_n;
  logic         pstart;
  logic [W-1:0] a_eff, b_eff, cnt;
  logic         cnt_clr, armed, active;

  assign pstart = (tbase_i == TB_START);

  pwm_dt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pwm_dt_shadow #(.W(W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .pstart_i (pstart),
    .a_we_i   (sh_a_we_i),
    .a_din_i  (sh_a_i),
    .b_we_i   (sh_b_we_i),
    .b_din_i  (sh_b_i),
    .a_eff_o  (a_eff),
    .b_eff_o  (b_eff)
  );

  pwm_dt_delay_cnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .run_i (armed),
    .cnt_o (cnt)
  );

  pwm_dt_edge_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .lead_i    (lead_mode_i),
    .pstart_i  (pstart),
    .tbase_i   (tbase_i),
    .a_eff_i   (a_eff),
    .b_eff_i   (b_eff),
    .cnt_i     (cnt),
    .cnt_clr_o (cnt_clr),
    .armed_o   (armed),
    .active_o  (active)
  );

  assign pwm_o = active ^ neg_pol_i;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pwm_o == neg_pol_i); // R1
  AST_POL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> pwm_o == neg_pol_i); // R9

endmodule

// File: tb/tb_pwm_dt_channel.sv
`timescale 1ns/1ps
module tb_pwm_dt_channel;

  localparam int W    = 16;
  localparam int MAXV = (1 << W) - 1;
  localparam int P    = 20;
  localparam int PLEN = 2 * P - 2;

  logic         clk = 1'b0;
  logic         arst_n = 1'b0;
  logic         en = 1'b0, lead = 1'b1, npol = 1'b0;
  logic [W-1:0] tbase = '0;
  logic         a_we = 1'b0, b_we = 1'b0;
  logic [W-1:0] a_d = '0, b_d = '0;
  logic         pwm;

  int checks = 0, errors = 0;
  bit done = 0;
  int gen_pos = 0;
  int cur_first, cur_last, cur_cnt;
  int last_first = -1, last_last = -1, last_cnt = 0;

  int m_a2 = 0, m_b2 = 0, m_a1 = 0, m_b1 = 0, m_mc = 0, m_cnt = 0;
  bit m_run = 0, m_armed = 0, m_act = 0;

  always #10 clk = ~clk;

  pwm_dt_channel #(.W(W)) dut (
    .clk(clk), .arst_n(arst_n), .en_i(en), .lead_mode_i(lead),
    .neg_pol_i(npol), .tbase_i(tbase), .sh_a_we_i(a_we), .sh_a_i(a_d),
    .sh_b_we_i(b_we), .sh_b_i(b_d), .pwm_o(pwm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: one clock of the channel as the requirements state it
  task automatic model_clock();
    bit ps, run_eff;
    int mc, ncnt;
    ps = (tbase == 1);
    if (ps) begin m_a1 = m_a2; m_b1 = m_b2; end
    if (a_we) m_a2 = int'(a_d);
    if (b_we) m_b2 = int'(b_d);
    run_eff = en && (m_run || ps);
    mc = ps ? 0 : m_mc;
    ncnt = m_cnt;
    if (m_armed && m_cnt < MAXV) ncnt = m_cnt + 1;
    if (!en) begin
      m_run = 0; m_mc = 0; m_armed = 0; m_act = 0;
    end else begin
      m_run = run_eff;
      m_mc = mc;
      if (run_eff) begin
        if (int'(tbase) == m_a1 && mc < 2) begin
          ncnt = 1;
          m_mc = mc + 1;
          if (mc == 0) begin
            if (lead) m_armed = 1;
            else begin m_act = 1; m_armed = 0; end
          end else begin
            if (lead) begin m_act = 0; m_armed = 0; end
            else m_armed = 1;
          end
        end else if (m_armed && m_cnt >= m_b1) begin
          m_armed = 0;
          m_act = lead;
        end
      end
    end
    m_cnt = ncnt;
  endtask

  task automatic step();
    int p = gen_pos;
    bit act_s;
    tbase = W'((p < P) ? p + 1 : 2 * P - 1 - p);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    a_we = 1'b0;
    b_we = 1'b0;
    chk("R4/R5/R6/R7 per-clock model", int'(pwm), int'(m_act ^ npol));
    act_s = pwm ^ npol;
    if (p == 0) begin cur_first = -1; cur_last = -1; cur_cnt = 0; end
    if (act_s) begin
      if (cur_first < 0) cur_first = p;
      cur_last = p;
      cur_cnt++;
    end
    if (p == PLEN - 1) begin
      last_first = cur_first; last_last = cur_last; last_cnt = cur_cnt;
    end
    gen_pos = (p + 1) % PLEN;
  endtask

  task automatic run_to(input int pos);
    do step(); while (gen_pos != pos);
  endtask

  task automatic run_periods(input int n);
    for (int i = 0; i < n * PLEN; i++) step();
  endtask

  task automatic count_active_to_end(output int n);
    n = 0;
    do begin
      step();
      if (pwm ^ npol) n++;
    end while (gen_pos != 0);
  endtask

  task automatic wr_a(input int v); a_d = W'(v); a_we = 1'b1; endtask
  task automatic wr_b(input int v); b_d = W'(v); b_we = 1'b1; endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", int'(pwm), 0);
    npol = 1'b1; #1;
    chk("R9 idle follows polarity at once", int'(pwm), 1);
    npol = 1'b0; #1;
    chk("R1 idle with enable low", int'(pwm), 0);

    // leading mode, A1=8, B1=3; enable in mid-period
    lead = 1'b1;
    wr_a(8); wr_b(3);
    run_to(10);
    en = 1'b1;
    count_active_to_end(n);
    chk("R2 no action before period start", n, 0);
    run_periods(2);
    chk("R4 lead first active index", last_first, 8 - 1 + 3);
    chk("R5 lead last active index", last_last, 2 * P - 2 - 8);
    chk("R8 lead width", last_cnt, 2 * (P - 8) - 3);

    // trailing mode, low-pulse polarity
    lead = 1'b0; npol = 1'b1;
    run_periods(2);
    chk("R6 trail first active index", last_first, 8 - 1);
    chk("R7 trail last active index", last_last, 2 * P - 2 - 8 + 3);
    chk("R8 trail width", last_cnt, 2 * (P - 8) + 3);
    chk("R9 idle level high with polarity 1", int'(pwm), 1);

    // shadow write halfway through a period
    run_to(15);
    wr_a(12);
    run_to(0);
    chk("R3 current period keeps old compare", last_first, 7);
    run_periods(1);
    chk("R3 new compare after reload", last_first, 11);
    chk("R8 trail width after reload", last_cnt, 2 * (P - 12) + 3);

    // zero dead time behaves as one
    lead = 1'b0; npol = 1'b0; lead = 1'b1;
    run_periods(1);
    wr_b(0);
    run_periods(2);
    chk("R10 zero dead time first index", last_first, 12 - 1 + 1);
    chk("R10 zero dead time width", last_cnt, 2 * (P - 12) - 1);
    wr_b(1);
    run_periods(2);
    chk("R10 dead time one width", last_cnt, 2 * (P - 12) - 1);

    // compare above the peak
    wr_a(25); wr_b(3);
    run_periods(2);
    chk("R11 unreachable compare stays idle", last_cnt, 0);

    // disable in mid-pulse, re-enable in mid-period
    wr_a(8);
    run_periods(2);
    chk("R4 lead restored", last_first, 10);
    run_to(20);
    en = 1'b0;
    step();
    chk("R2 disable goes idle next clock", int'(pwm), 0);
    run_to(22);
    en = 1'b1;
    count_active_to_end(n);
    chk("R2 re-enable waits for period start", n, 0);
    run_periods(1);
    chk("R2 resumes after period start", last_cnt, 2 * (P - 8) - 3);

    // compare equal to 1: match on the period-start clock uses the new value
    wr_a(1);
    run_periods(2);
    chk("R3 same-clock compare at period start", last_first, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule